// File: doc/BRIEF.md
# Latched Dual Countdown Timer Unit

Two 16-bit down-counters sit behind a small byte-wide register window. The first timer is never loaded directly: software stages a reload value in a separate 16-bit latch one byte at a time, and writing the counter's upper byte location copies the whole latch into the counter and starts it. The second timer is loaded straight into the counter. Its lower byte write sets the counter and halts it. Its upper byte write adds into the upper half and starts it.

A running counter drops by one on every clock where `tick_en` is high. A counter already at zero that gets another tick stays at zero, stops, and raises its own interrupt line. Reading or writing certain register locations clears each interrupt line. The auxiliary control register can also restart the first timer without reloading it. The block is a timer slice of a larger peripheral, driven by a host bus that issues single-cycle read and write strobes.

Top module: `twin_down_timer`

## Requirements
- R1: After reset both counters, the latch and the auxiliary register read as 0, both timers are stopped and `tmr1_irq` and `tmr2_irq` are low.
- R2: A write to offset 0x6 or 0x4 sets only the latch low byte, and a write to 0x7 sets only the latch high byte and clears `tmr1_irq`. Neither write changes the timer 1 counter.
- R3: A write to offset 0x5 copies the full 16-bit latch into the timer 1 counter, starts timer 1 and clears `tmr1_irq`. The written data is ignored.
- R4: A running counter decreases by exactly one on each clock with `tick_en` high. A counter holds its value when `tick_en` is low or when the timer is stopped.
- R5: A running counter at 0 that receives a tick stays at 0, stops and sets its interrupt line. A counter loaded with N therefore raises its line after N+1 ticks, and further ticks have no effect until it is restarted.
- R6: A read of offset 0x4 returns the timer 1 counter's low byte and clears `tmr1_irq`. Reads of 0x5 (counter high), 0x6 (latch low) and 0x7 (latch high) have no side effect.
- R7: A write of byte b to offset 0x8 sets the timer 2 counter to {0x00, b}, stops timer 2 and clears `tmr2_irq`.
- R8: A write of byte b to offset 0x9 adds b·256 to the timer 2 counter, modulo 2^16, starts timer 2 and clears `tmr2_irq`.
- R9: A read of offset 0x8 returns the timer 2 low byte and clears `tmr2_irq`. A read of 0x9 returns the high byte with no side effect.
- R10: Offset 0xB holds a readable auxiliary byte. Writing it with bit 6 set starts timer 1 from its present count without reloading it.
- R11: If an expiry and a flag-clearing access fall in the same cycle, the flag ends up set. If a load and a tick fall in the same cycle, the counter takes the loaded value.
- R12: Reads of offsets outside 0x4–0x9 and 0xB return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserted asynchronously, released synchronously upstream |
| tick_en | input | 1 | Count enable for both running timers |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe (read side effects) |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when `rd_en` is low |
| tmr1_irq | output | 1 | Timer 1 expiry flag |
| tmr2_irq | output | 1 | Timer 2 expiry flag |

## Verification
A counter that skips or repeats a decrement shows up at the next counter read. It also moves the interrupt edge away from tick N+1 after loading, so sweeps over many load values and part-way reads expose it within one load period. A run flag stuck high shows as a line that rises again after it was cleared, or as a counter that moves after expiry. A run flag stuck low shows as a count that never moves. A wrong latch or byte-steering path shows as a bad value on the first read after the load. A missing or misplaced flag clear shows on the interrupt pins in the cycle right after the access.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned CONT_BIT = 6;

  typedef enum logic [ADDR_W-1:0] {
    OFS_T1_CNT_LO = 4'h4,
    OFS_T1_CNT_HI = 4'h5,
    OFS_T1_LAT_LO = 4'h6,
    OFS_T1_LAT_HI = 4'h7,
    OFS_T2_LO     = 4'h8,
    OFS_T2_HI     = 4'h9,
    OFS_AUX       = 4'hB
  } ofs_e;

  typedef struct packed {
    logic t1_lat_lo_wr;
    logic t1_lat_hi_wr;
    logic t1_arm;
    logic t1_rd_clr;
    logic t2_lo_wr;
    logic t2_hi_wr;
    logic t2_rd_clr;
    logic aux_wr;
  } strobe_t;
endpackage

// File: rtl/dct_decode.sv
module dct_decode
  import dct_pkg::*;
(
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           st
);
  always_comb begin
    st              = '0;
    st.t1_lat_lo_wr = wr_en && ((addr == OFS_T1_LAT_LO) || (addr == OFS_T1_CNT_LO));
    st.t1_lat_hi_wr = wr_en && (addr == OFS_T1_LAT_HI);
    st.t1_arm       = wr_en && (addr == OFS_T1_CNT_HI);
    st.t1_rd_clr    = rd_en && (addr == OFS_T1_CNT_LO);
    st.t2_lo_wr     = wr_en && (addr == OFS_T2_LO);
    st.t2_hi_wr     = wr_en && (addr == OFS_T2_HI);
    st.t2_rd_clr    = rd_en && (addr == OFS_T2_LO);
    st.aux_wr       = wr_en && (addr == OFS_AUX);
  end
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         start,
  input  logic         stop,
  input  logic         flag_clr,
  output logic [W-1:0] cnt,
  output logic         flag
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         flag_q, flag_d;
  logic         dec, expire;

  assign dec    = run_q && tick_en && !load_en && !stop;
  assign expire = dec && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_en)                 cnt_d = load_val;
    else if (dec && !expire)     cnt_d = cnt_q - 1'b1;

    run_d = run_q;
    if (stop)                    run_d = 1'b0;
    else if (start)              run_d = 1'b1;
    else if (expire)             run_d = 1'b0;

    flag_d = flag_q;
    if (expire)                  flag_d = 1'b1;
    else if (flag_clr)           flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> cnt_q == $past(load_val)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && (!run_q || !tick_en)) |=> $stable(cnt_q)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && !load_en && !stop && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R4
  AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && !load_en && !stop && !start && cnt_q == '0) |=> (flag_q && !run_q && cnt_q == '0)); // R5
  AST_CLEAR_WINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(run_q && tick_en && !load_en && !stop && cnt_q == '0)) |=> !flag_q); // R11
endmodule

// File: rtl/twin_down_timer.sv
module twin_down_timer
  import dct_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              tmr1_irq,
  output logic              tmr2_irq
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  strobe_t           st;
  logic [CNT_W-1:0]  lat_q, lat_d;
  logic [BYTE_W-1:0] aux_q, aux_d;
  logic [CNT_W-1:0]  t1_cnt, t2_cnt, t2_load;
  logic              t1_start;

  dct_decode u_dec (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .st    (st)
  );

  always_comb begin
    lat_d = lat_q;
    if (st.t1_lat_lo_wr) lat_d[BYTE_W-1:0]     = wdata;
    if (st.t1_lat_hi_wr) lat_d[CNT_W-1:BYTE_W] = wdata;
    aux_d = aux_q;
    if (st.aux_wr)       aux_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      aux_q <= '0;
    end else begin
      lat_q <= lat_d;
      aux_q <= aux_d;
    end
  end

  assign t1_start = st.t1_arm || (st.aux_wr && wdata[CONT_BIT]);
  assign t2_load  = st.t2_lo_wr ? {{BYTE_W{1'b0}}, wdata}
                                : t2_cnt + {wdata, {BYTE_W{1'b0}}};

  dct_counter #(.W(CNT_W)) u_t1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load_en  (st.t1_arm),
    .load_val (lat_q),
    .start    (t1_start),
    .stop     (1'b0),
    .flag_clr (st.t1_arm || st.t1_lat_hi_wr || st.t1_rd_clr),
    .cnt      (t1_cnt),
    .flag     (tmr1_irq)
  );

  dct_counter #(.W(CNT_W)) u_t2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load_en  (st.t2_lo_wr || st.t2_hi_wr),
    .load_val (t2_load),
    .start    (st.t2_hi_wr),
    .stop     (st.t2_lo_wr),
    .flag_clr (st.t2_lo_wr || st.t2_hi_wr || st.t2_rd_clr),
    .cnt      (t2_cnt),
    .flag     (tmr2_irq)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_T1_CNT_LO: rdata = t1_cnt[BYTE_W-1:0];
        OFS_T1_CNT_HI: rdata = t1_cnt[CNT_W-1:BYTE_W];
        OFS_T1_LAT_LO: rdata = lat_q[BYTE_W-1:0];
        OFS_T1_LAT_HI: rdata = lat_q[CNT_W-1:BYTE_W];
        OFS_T2_LO:     rdata = t2_cnt[BYTE_W-1:0];
        OFS_T2_HI:     rdata = t2_cnt[CNT_W-1:BYTE_W];
        OFS_AUX:       rdata = aux_q;
        default:       rdata = '0;
      endcase
    end
  end

  AST_ARM_COPIES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_T1_CNT_HI) |=> (t1_cnt == $past(lat_q) && !tmr1_irq)); // R3
  AST_LATCH_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_T1_LAT_HI && !tick_en) |=> (t1_cnt == $past(t1_cnt) && !tmr1_irq)); // R2
  AST_T2_LOW_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_T2_LO) |=> (t2_cnt[CNT_W-1:BYTE_W] == '0 && !tmr2_irq)); // R7
  AST_HIGH_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_T1_CNT_HI && tmr1_irq) |=> tmr1_irq); // R6
endmodule

// File: tb/twin_down_timer_bench.sv
`timescale 1ns/1ps
module twin_down_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tmr1_irq, tmr2_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  twin_down_timer u_twin_down_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tmr1_irq(tmr1_irq), .tmr2_irq(tmr2_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic rd16(input logic [3:0] lo, output int v);
    logic [7:0] h, l;
    rd(lo + 4'd1, h);
    rd(lo, l);
    v = {h, l};
  endtask

  task automatic arm1(input int n);
    wr(4'h6, n[7:0]);
    wr(4'h7, n[15:8]);
    wr(4'h5, 8'h5A);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int v;
    int n1[8] = '{0, 1, 2, 3, 7, 255, 256, 300};
    logic [7:0] pat[4] = '{8'h00, 8'h01, 8'h80, 8'hFF};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 4; a <= 11; a++) begin
      rd(a[3:0], b);
      chk("R1 reg", b, 0);
    end
    chk("R1 tmr1_irq", tmr1_irq, 0);
    chk("R1 tmr2_irq", tmr2_irq, 0);

    // R2/R6: latch bytes, both low-byte paths
    wr(4'h6, 8'h34); wr(4'h7, 8'h12);
    rd(4'h6, b); chk("R2 latch lo", b, 8'h34);
    rd(4'h7, b); chk("R2 latch hi", b, 8'h12);
    wr(4'h4, 8'h77);
    rd(4'h6, b); chk("R2 write 0x4 to latch lo", b, 8'h77);
    rd16(4'h4, v); chk("R2 counter untouched", v, 0);

    // R3/R4/R5/R6: sweep of load values and part-way reads
    foreach (n1[i]) begin
      for (int s = 0; s < 3; s++) begin
        int n, k;
        n = n1[i];
        k = (s == 0) ? 0 : (s == 1) ? n / 2 : n;
        arm1(n);
        chk("R3 irq cleared on arm", tmr1_irq, 0);
        ticks(k);
        rd16(4'h4, v); chk("R4 partial count", v, n - k);
        chk("R5 no early irq", tmr1_irq, 0);
        ticks(n - k + 1);
        chk("R5 irq at N+1 ticks", tmr1_irq, 1);
        rd(4'h5, b); chk("R5 held at zero hi", b, 0);
        rd(4'h6, b); chk("R6 latch lo read", b, n & 8'hFF);
        rd(4'h7, b); chk("R6 latch hi read", b, (n >> 8) & 8'hFF);
        chk("R6 reads 5/6/7 keep irq", tmr1_irq, 1);
        rd(4'h4, b); chk("R6 low read value", b, 0);
        chk("R6 low read clears irq", tmr1_irq, 0);
        ticks(3);
        chk("R5 stopped, no re-raise", tmr1_irq, 0);
        rd16(4'h4, v); chk("R5 stays zero", v, 0);
      end
    end

    // R2: latch-high write clears the timer 1 flag
    arm1(1); ticks(2);
    chk("R5 irq before latch write", tmr1_irq, 1);
    wr(4'h7, 8'h00);
    chk("R2 latch hi clears irq", tmr1_irq, 0);

    // R10: auxiliary restart without reload
    wr(4'h6, 8'd99); wr(4'h7, 8'd0);
    wr(4'hB, 8'h40);
    rd(4'hB, b); chk("R10 aux readback", b, 8'h40);
    rd16(4'h4, v); chk("R10 no reload", v, 0);
    ticks(1);
    chk("R10 restarted timer expires", tmr1_irq, 1);
    rd(4'h4, b);
    wr(4'hB, 8'hBF);
    ticks(2);
    chk("R10 bit6 clear does not start", tmr1_irq, 0);
    rd(4'hB, b); chk("R10 aux readback 2", b, 8'hBF);

    // R7/R8: timer 2 byte combinations and additive high write
    foreach (pat[i]) begin
      foreach (pat[j]) begin
        wr(4'h8, pat[i]);
        rd16(4'h8, v); chk("R7 low write", v, pat[i]);
        wr(4'h9, pat[j]);
        rd16(4'h8, v); chk("R8 combined", v, {pat[j], pat[i]});
        wr(4'h9, 8'h02);
        rd16(4'h8, v); chk("R8 additive", v, ({pat[j], pat[i]} + 16'h0200) & 16'hFFFF);
      end
    end
    wr(4'h8, 8'd20); wr(4'h9, 8'd0);
    ticks(5);
    wr(4'h9, 8'h01);
    rd16(4'h8, v); chk("R8 add to running count", v, 15 + 256);
    wr(4'h8, 8'd3);
    ticks(5);
    rd16(4'h8, v); chk("R7 low write stops", v, 3);
    chk("R7 no irq while stopped", tmr2_irq, 0);

    // R5/R7/R8/R9: timer 2 expiry and its clearing accesses
    wr(4'h9, 8'h00); ticks(4);
    chk("R5 t2 irq at N+1", tmr2_irq, 1);
    rd(4'h9, b); chk("R9 hi read value", b, 0);
    chk("R9 hi read keeps irq", tmr2_irq, 1);
    rd(4'h8, b);
    chk("R9 low read clears irq", tmr2_irq, 0);
    wr(4'h8, 8'd0); wr(4'h9, 8'd0); ticks(1);
    chk("R5 t2 zero load", tmr2_irq, 1);
    wr(4'h8, 8'd0);
    chk("R7 low write clears irq", tmr2_irq, 0);
    wr(4'h9, 8'd0); ticks(1);
    chk("R5 t2 re-expire", tmr2_irq, 1);
    wr(4'h9, 8'd0);
    chk("R8 high write clears irq", tmr2_irq, 0);

    // R11: expiry beats read-clear in the same cycle
    arm1(0);
    @(negedge clk); rd_en = 1'b1; addr = 4'h4; tick_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; tick_en = 1'b0;
    chk("R11 expiry wins over clear", tmr1_irq, 1);
    // R11: load beats tick in the same cycle
    arm1(50); ticks(2);
    wr(4'h6, 8'd10); wr(4'h7, 8'd0);
    @(negedge clk); wr_en = 1'b1; addr = 4'h5; tick_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick_en = 1'b0;
    rd16(4'h4, v); chk("R11 load wins over tick", v, 10);

    // R12: unused offsets
    wr(4'h0, 8'hAA); wr(4'h3, 8'h55); wr(4'hF, 8'hFF);
    foreach (pat[i]) begin
      logic [3:0] ua;
      ua = (i == 0) ? 4'h0 : (i == 1) ? 4'h3 : (i == 2) ? 4'hA : 4'hF;
      rd(ua, b); chk("R12 unused read", b, 0);
    end
    rd16(4'h4, v); chk("R12 t1 untouched", v, 10);
    rd(4'h6, b); chk("R12 latch untouched", b, 8'd10);
    rd(4'hB, b); chk("R12 aux untouched", b, 8'hBF);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule